// File: doc/BRIEF.md
# Dual Double-Buffered DAC Register Bank

This block is the digital front end of a two-channel converter with a parallel data bus. Each channel has two register stages. The first is an input register, written from the bus while chip select is low. The channel line picks which of the two input registers is written. The second is a DAC register. It takes the input-register value while that channel's load strobe is low. The block presents both DAC register codes, one output-enable flag per channel and one update pulse per channel.

The host can fill both input registers one after the other and then pull both strobes low together, so that both outputs change in the same cycle. If a strobe is held low permanently, that channel follows each write directly (single-buffered use). An asynchronous reset clears every register. A shutdown input only drops the output-enable flags; writes and loads carry on as normal.

All inputs are treated as asynchronous. They are sampled on a fast system clock through two flip-flop stages, and the synchronised copies drive the register logic. The code width is a parameter. A narrower code takes the upper bits of the 12-bit bus and ignores the lowest bus positions.

Top module: `dual_dac_regbank`

## Requirements
- R1: The channel line selects channel A when it is 1 and channel B when it is 0. It has an effect only while chip select is low.
- R2: While chip select is low, the selected input register follows the data bus. It keeps the value present when chip select rises, and later bus changes with chip select high do not reach it.
- R3: A DAC register passes its input register through while its load strobe is low. It holds its value while the strobe is high, even when the input register is rewritten.
- R4: With both load strobes low at once, both DAC registers change at the same clock edge.
- R5: With reset low, both input registers and both DAC registers are zero and both output-enable flags are low, whatever the other inputs do. After reset is released, a load with no new write gives zero.
- R6: While shutdown is low, both output-enable flags are 0, and writes and loads still change the registers. When shutdown returns high, the flags go back to 1 and the codes show the latest DAC register contents.
- R7: Bus bit 11 is the most significant bit. A code of width W is taken from bus[11 : 12-W]. For W=10, bus bits 1 and 0 are ignored.
- R8: A change on an input appears on the outputs at the third rising clock edge after it is applied (two synchroniser stages, then the register stage).
- R9: An update flag is 1 for exactly one cycle each time its channel's code changes. It stays 0 when a load leaves the code unchanged.
- R10: A write and a load to the same channel in the same cycle place the new bus value in the DAC register at the same edge as in the input register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| cs_n | input | 1 | Chip select, active low; input registers follow the bus while low |
| ch_sel | input | 1 | Channel select: 1 = A, 0 = B |
| load_a_n | input | 1 | Channel A DAC register load strobe, active low |
| load_b_n | input | 1 | Channel B DAC register load strobe, active low |
| shdn_n | input | 1 | Shutdown, active low; drops the output enables |
| data | input | 12 | Parallel data bus, bit 11 most significant |
| code_a | output | CODE_W | Channel A DAC register code |
| code_b | output | CODE_W | Channel B DAC register code |
| oe_a | output | 1 | Channel A output buffer active |
| oe_b | output | 1 | Channel B output buffer active |
| upd_a | output | 1 | One-cycle pulse when code_a changes |
| upd_b | output | 1 | One-cycle pulse when code_b changes |

## Verification
The input registers cannot be read directly. If one of them holds a wrong value, the error appears at the ports only on the next load of that channel. That is three edges after the strobe goes low, or at once when the strobe is already held low. The bench therefore follows each write with a load and compares both codes. A corrupted DAC register, or a wrong timing for oe or upd, shows on the outputs at the next edge. The checks sample exactly at the third edge after each stimulus, so an extra or a missing stage is caught.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;

  localparam int BUS_W = 12;
  localparam int SYNC_STAGES = 2;

  typedef enum logic {
    CH_B = 1'b0,
    CH_A = 1'b1
  } chan_e;

  // Right-aligns a code of width cw that sits in the top of the bus.
  function automatic logic [BUS_W-1:0] align_code(input logic [BUS_W-1:0] bus,
                                                  input int unsigned cw);
    return bus >> (BUS_W - cw);
  endfunction

  // Strobe inputs are active low.
  function automatic logic strobe_on(input logic level_n);
    return ~level_n;
  endfunction

endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              ld_en,
  input  logic              pwr_on,
  output logic [CODE_W-1:0] in_q,
  output logic [CODE_W-1:0] code_q,
  output logic              oe_q,
  output logic              upd_q
);
  logic [CODE_W-1:0] in_nxt;
  logic [CODE_W-1:0] dac_nxt;
  logic              code_moves;

  always_comb begin
    in_nxt     = wr_en ? wr_code : in_q;
    dac_nxt    = ld_en ? in_nxt : code_q;
    code_moves = (dac_nxt != code_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      code_q <= '0;
      oe_q   <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      in_q   <= in_nxt;
      code_q <= dac_nxt;
      oe_q   <= pwr_on;
      upd_q  <= code_moves;
    end
  end

  // R2: an input register is written only while it is selected
  p_in_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(in_q));

  // R3: a closed strobe freezes the DAC register
  p_dac_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> $stable(code_q));

  // R10: a write and a load in the same cycle flow through together
  p_flow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && wr_en) |=> (code_q == $past(wr_code)));

  // R6: output enable follows the power state one edge later
  p_oe_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_on |=> oe_q);
  p_oe_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> !oe_q);

  // R9: an update pulse only marks a real change of code
  p_upd_real_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> (code_q != $past(code_q)));
  p_upd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |-> (code_q == $past(code_q)));
endmodule

// File: rtl/dual_dac_regbank.sv
module dual_dac_regbank
  import dac_bank_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ch_sel,
  input  logic              load_a_n,
  input  logic              load_b_n,
  input  logic              shdn_n,
  input  logic [BUS_W-1:0]  data,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              oe_a,
  output logic              oe_b,
  output logic              upd_a,
  output logic              upd_b
);
  localparam int CTRL_W = 5;
  localparam int SYNC_W = CTRL_W + BUS_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, {BUS_W{1'b0}}};
  localparam int NCH = 2;

  logic [SYNC_W-1:0] sync_q;
  logic              cs_n_s, sel_s, lda_n_s, ldb_n_s, shdn_n_s;
  logic [BUS_W-1:0]  data_s;
  logic              cs_n_d;
  logic              cs_rise;
  logic [BUS_W-1:0]  aligned;
  logic [CODE_W-1:0] wr_code;
  logic [NCH-1:0]    wr_en;
  logic [NCH-1:0]    ld_en;
  logic [CODE_W-1:0] in_v   [NCH];
  logic [CODE_W-1:0] code_v [NCH];
  logic [NCH-1:0]    oe_v;
  logic [NCH-1:0]    upd_v;

  dac_sync #(
    .W       (SYNC_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, ch_sel, load_a_n, load_b_n, shdn_n, data}),
    .q     (sync_q)
  );

  assign {cs_n_s, sel_s, lda_n_s, ldb_n_s, shdn_n_s, data_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_n_d <= 1'b1;
    else        cs_n_d <= cs_n_s;
  end

  assign cs_rise = cs_n_s & ~cs_n_d;
  assign aligned = align_code(data_s, CODE_W);
  assign wr_code = aligned[CODE_W-1:0];

  // Channel index: 1 = A, 0 = B
  assign wr_en[int'(CH_A)] = strobe_on(cs_n_s) && (chan_e'(sel_s) == CH_A);
  assign wr_en[int'(CH_B)] = strobe_on(cs_n_s) && (chan_e'(sel_s) == CH_B);
  assign ld_en[int'(CH_A)] = strobe_on(lda_n_s);
  assign ld_en[int'(CH_B)] = strobe_on(ldb_n_s);

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      dac_channel #(.CODE_W(CODE_W)) u_ch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en[c]),
        .wr_code (wr_code),
        .ld_en   (ld_en[c]),
        .pwr_on  (shdn_n_s),
        .in_q    (in_v[c]),
        .code_q  (code_v[c]),
        .oe_q    (oe_v[c]),
        .upd_q   (upd_v[c])
      );
    end
  endgenerate

  assign code_a = code_v[int'(CH_A)];
  assign code_b = code_v[int'(CH_B)];
  assign oe_a   = oe_v[int'(CH_A)];
  assign oe_b   = oe_v[int'(CH_B)];
  assign upd_a  = upd_v[int'(CH_A)];
  assign upd_b  = upd_v[int'(CH_B)];

  // R1: at most one input register is written in any cycle
  p_one_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  // R2: the chip-select rising edge freezes both input registers
  p_cs_rise_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> ($stable(in_v[0]) && $stable(in_v[1])));

  // R4: both strobes open means both codes take their input registers
  p_joint_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (&ld_en && !(|wr_en)) |=> (code_v[0] == $past(in_v[0]) && code_v[1] == $past(in_v[1])));

  // R6: both output enables agree at all times
  p_oe_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_a == oe_b);
endmodule

// File: tb/dual_dac_regbank_test.sv
`timescale 1ns/1ps
module dual_dac_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, ch_sel = 1'b0, load_a_n = 1'b1, load_b_n = 1'b1, shdn_n = 1'b1;
  logic [11:0] data = '0;
  logic [11:0] code_a, code_b;
  logic        oe_a, oe_b, upd_a, upd_b;
  logic [9:0]  n_code_a, n_code_b;
  logic        n_oe_a, n_oe_b, n_upd_a, n_upd_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dual_dac_regbank uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ch_sel(ch_sel),
    .load_a_n(load_a_n), .load_b_n(load_b_n), .shdn_n(shdn_n), .data(data),
    .code_a(code_a), .code_b(code_b), .oe_a(oe_a), .oe_b(oe_b),
    .upd_a(upd_a), .upd_b(upd_b));

  dual_dac_regbank #(.CODE_W(10)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ch_sel(ch_sel),
    .load_a_n(load_a_n), .load_b_n(load_b_n), .shdn_n(shdn_n), .data(data),
    .code_a(n_code_a), .code_b(n_code_b), .oe_a(n_oe_a), .oe_b(n_oe_b),
    .upd_a(n_upd_a), .upd_b(n_upd_b));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic cs, input logic sel, input logic la, input logic lb,
                       input logic sh, input logic [11:0] d);
    cs_n = cs; ch_sel = sel; load_a_n = la; load_b_n = lb; shdn_n = sh; data = d;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {cs_n, sel, lda_n, ldb_n, shdn_n, data, exp_a, exp_b, exp_oe}
  localparam int NV = 14;
  localparam logic [41:0] VEC [NV] = '{
    {5'b1_1_11_1, 12'h000, 12'h000, 12'h000, 1'b1},
    {5'b0_1_11_1, 12'h123, 12'h000, 12'h000, 1'b1},
    {5'b1_1_01_1, 12'h123, 12'h123, 12'h000, 1'b1},
    {5'b0_0_11_1, 12'h456, 12'h123, 12'h000, 1'b1},
    {5'b1_0_10_1, 12'h456, 12'h123, 12'h456, 1'b1},
    {5'b0_1_11_1, 12'hABC, 12'h123, 12'h456, 1'b1},
    {5'b0_0_11_1, 12'h0DE, 12'h123, 12'h456, 1'b1},
    {5'b1_0_00_1, 12'hFFF, 12'hABC, 12'h0DE, 1'b1},
    {5'b0_1_00_1, 12'h777, 12'h777, 12'h0DE, 1'b1},
    {5'b1_1_11_0, 12'h000, 12'h777, 12'h0DE, 1'b0},
    {5'b0_0_10_0, 12'h321, 12'h777, 12'h321, 1'b0},
    {5'b1_0_11_1, 12'h321, 12'h777, 12'h321, 1'b1},
    {5'b1_1_01_1, 12'h999, 12'h777, 12'h321, 1'b1},
    {5'b1_0_00_1, 12'h555, 12'h777, 12'h321, 1'b1}
  };
  localparam string TAGS [NV] = '{
    "R6 idle", "R3 write A held", "R3 load A", "R1 write B", "R3 load B",
    "R1 write A only", "R2 select switch", "R4 joint load", "R10 flow-through",
    "R6 shutdown", "R6 load in shutdown", "R6 wake", "R2 bus ignored", "R2 R4 no change"
  };

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [41:0] v;
    int          pulses;
    // R5: reset state
    wait_neg(4);
    chk("R5 reset code_a", code_a, 0);
    chk("R5 reset code_b", code_b, 0);
    chk("R5 reset oe", {oe_a, oe_b}, 0);
    rst_n = 1'b1;
    wait_neg(4);
    chk("R6 oe after reset", {oe_a, oe_b}, 2'b11);

    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      drive(v[41], v[40], v[39], v[38], v[37], v[36:25]);
      wait_neg(4);
      chk({TAGS[k], " code_a"}, code_a, v[24:13]);
      chk({TAGS[k], " code_b"}, code_b, v[12:1]);
      chk({TAGS[k], " oe"}, {oe_a, oe_b}, {2{v[0]}});
    end

    // R8 latency and R9 pulse: write and load A with a fresh value
    drive(1, 1, 1, 1, 1, 12'h555);
    wait_neg(4);
    drive(0, 1, 0, 1, 1, 12'h2A5);
    wait_neg(2);
    chk("R8 before third edge", code_a, 12'h777);
    wait_neg(1);
    chk("R8 at third edge", code_a, 12'h2A5);
    chk("R9 pulse high", upd_a, 1);
    chk("R9 other channel quiet", upd_b, 0);
    wait_neg(1);
    chk("R9 pulse one cycle", upd_a, 0);

    // R9: rewriting the same value with the strobe open gives no pulse
    pulses = 0;
    drive(1, 1, 0, 1, 1, 12'h2A5);
    for (int i = 0; i < 6; i++) begin
      wait_neg(1);
      pulses += int'(upd_a);
    end
    drive(0, 1, 0, 1, 1, 12'h2A5);
    for (int i = 0; i < 6; i++) begin
      wait_neg(1);
      pulses += int'(upd_a);
    end
    chk("R9 no pulse on same value", pulses, 0);

    // R7: bus alignment on the 10-bit instance
    drive(0, 1, 0, 1, 1, 12'hABF);
    wait_neg(4);
    chk("R7 wide code", code_a, 12'hABF);
    chk("R7 narrow code", n_code_a, 10'h2AF);
    drive(0, 1, 0, 1, 1, 12'h003);
    wait_neg(4);
    chk("R7 low bits ignored", n_code_a, 10'h000);
    drive(0, 1, 0, 1, 1, 12'h800);
    wait_neg(4);
    chk("R7 msb", n_code_a, 10'h200);

    // R5: reset wins over an active write and load
    drive(0, 0, 0, 0, 1, 12'hFAB);
    wait_neg(2);
    rst_n = 1'b0;
    wait_neg(3);
    chk("R5 reset during write code_a", code_a, 0);
    chk("R5 reset during write code_b", code_b, 0);
    chk("R5 reset during write oe", {oe_a, oe_b}, 0);
    drive(1, 0, 0, 0, 1, 12'hFAB);
    wait_neg(1);
    rst_n = 1'b1;
    wait_neg(5);
    chk("R5 cleared input regs A", code_a, 0);
    chk("R5 cleared input regs B", code_b, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule